// File: doc/BRIEF.md
# Horizontal Sync Generator and Inserter

This block produces the horizontal line timing for a digital video output path and writes a sync level into the outgoing sample stream ahead of the converters. A line counter runs on the pixel clock. It starts each line at 1, and that first pixel is also the first pixel of the sync pulse. The pulse lasts for a programmed number of pixels. During the pulse, every channel carries a programmable sync depth below the blank level. Outside the pulse, blanked pixels carry the blank level. Active pixels carry the blank level plus the input sample, plus an optional setup pedestal.

The three sample channels pass through unchanged in kind, with no colour conversion between them. In master mode the counter wraps after the programmed line length. In slave mode a falling edge on an external active-low line-sync input restarts it. All configuration inputs are captured into shadow registers only when the counter restarts, so a line is never built from a mix of old and new settings.

Top module: `hsync_inserter`

## Requirements
- R1: While reset is asserted, `hcount_o` is 0 and `sync_o` is 0. On the first clock edge after reset is released the counter becomes 1 and the configuration is captured.
- R2: In master mode (`slave_en_i`=0) the counter steps by one each clock from 1 up to the effective line length. On the next edge it returns to 1.
- R3: `sync_o` is 1 exactly while `hcount_o` is between 1 and the captured sync width, so each line carries that many sync pixels. A width of 0 gives no sync.
- R4: While `sync_o` is 1, every channel of `pix_o` equals BLANK_LVL minus `sync_amp_i`×SYNC_STEP, clamped at 0. This holds regardless of `blank_i` and `pix_i`.
- R5: On an active pixel (no sync, `blank_i`=0), each channel equals BLANK_LVL plus the input sample, plus PED_LVL when the captured setup bit is 1. The result is clamped at 2^DATA_W−1.
- R6: On a blanked pixel outside sync, every channel equals BLANK_LVL. The pedestal and the input sample have no effect.
- R7: Channel i occupies bits [i×DATA_W +: DATA_W] of `pix_i` and `pix_o`. Each channel is composed only from its own input field.
- R8: A line length below sync width + 2 is raised to sync width + 2.
- R9: A change on any configuration input takes effect only from the next pixel with `hcount_o`=1. The rest of the current line keeps the old values.
- R10: In slave mode the counter ignores the line length. It returns to 1 on the edge after `ext_hsync_ni` is seen going from 1 to 0. Otherwise it counts up and holds at 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_len_i | input | 12 | Line length in pixels |
| sync_width_i | input | 8 | Sync pulse width in pixels |
| sync_amp_i | input | 8 | Sync depth in steps below blank |
| setup_en_i | input | 1 | Add setup pedestal to active video |
| slave_en_i | input | 1 | Restart lines from the external sync input |
| ext_hsync_ni | input | 1 | External active-low line sync |
| blank_i | input | 1 | Current sample is blanked |
| pix_i | input | NUM_CH×DATA_W | Input samples, channel 0 in the low bits |
| pix_o | output | NUM_CH×DATA_W | Composed samples |
| sync_o | output | 1 | Sync interval flag |
| hcount_o | output | 12 | Line counter |

## Verification
The bench walks a full line pixel by pixel to catch an off-by-one in the wrap point or in the sync width. Such a bug would show up as a line one pixel long or short, or a sync pulse one pixel wide or narrow. It drives a sync depth larger than the blank level: a design without the clamp would wrap to a high code. It drives a sample that overflows with the pedestal added: a design without the clamp would wrap to a low code. It changes the setup bit and the sync depth in mid-line, which a design with unshadowed configuration would apply at once. In slave mode it runs the counter past the programmed length to its hold value, to catch a design that still wraps internally or rolls over to 0.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned SW_W  = 8;
  localparam int unsigned AMP_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SW_W-1:0]  sw_t;
  typedef logic [AMP_W-1:0] amp_t;

  typedef struct packed {
    cnt_t len;
    sw_t  width;
    amp_t amp;
    logic setup;
    logic slave;
  } hcfg_t;
endpackage

// File: rtl/hsi_shadow.sv
module hsi_shadow
  import hsi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  hcfg_t cfg_i,
  output hcfg_t cfg_o
);
  cnt_t  min_len;
  hcfg_t cfg_d, cfg_q;

  // keep at least one non-sync pixel per line
  always_comb begin
    min_len = cnt_t'(cfg_i.width) + cnt_t'(2);
    cfg_d   = cfg_i;
    if (cfg_i.len < min_len) cfg_d.len = min_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/hsi_line_timer.sv
module hsi_line_timer
  import hsi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t len_i,
  input  sw_t  width_i,
  input  logic slave_i,
  input  logic ext_hsync_ni,
  output logic restart_o,
  output logic sync_o,
  output cnt_t cnt_o
);
  cnt_t cnt_q, cnt_d;
  logic ext_q;
  logic ext_fall;

  assign ext_fall = ext_q & ~ext_hsync_ni;

  always_comb begin
    if (cnt_q == '0)  restart_o = 1'b1;
    else if (slave_i) restart_o = ext_fall;
    else              restart_o = (cnt_q >= len_i);

    if (restart_o)         cnt_d = cnt_t'(1);
    else if (cnt_q == '1)  cnt_d = cnt_q;
    else                   cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ext_q <= ext_hsync_ni;
    end
  end

  assign sync_o = (cnt_q != '0) && (cnt_q <= cnt_t'(width_i));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/hsi_lane.sv
module hsi_lane
  import hsi_pkg::*;
#(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned BLANK_LVL = 240,
  parameter int unsigned PED_LVL   = 20,
  parameter int unsigned SYNC_STEP = 1
) (
  input  logic              sync_i,
  input  logic              blank_i,
  input  logic              setup_i,
  input  amp_t              amp_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic [DATA_W-1:0] pix_o
);
  localparam int unsigned SW = DATA_W + AMP_W + 2;
  localparam logic [SW-1:0] BLANK_W = SW'(BLANK_LVL);
  localparam logic [SW-1:0] PED_W   = SW'(PED_LVL);
  localparam logic [SW-1:0] MAX_W   = SW'((2 ** DATA_W) - 1);

  logic [SW-1:0] depth, act_sum;

  always_comb begin
    depth   = SW'(amp_i) * SW'(SYNC_STEP);
    act_sum = BLANK_W + SW'(pix_i) + (setup_i ? PED_W : '0);
    if (sync_i)
      pix_o = (depth >= BLANK_W) ? '0 : DATA_W'(BLANK_W - depth);
    else if (blank_i)
      pix_o = DATA_W'(BLANK_W);
    else if (act_sum > MAX_W)
      pix_o = '1;
    else
      pix_o = DATA_W'(act_sum);
  end
endmodule

// File: rtl/hsync_inserter.sv
module hsync_inserter
  import hsi_pkg::*;
#(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned BLANK_LVL = 240,
  parameter int unsigned PED_LVL   = 20,
  parameter int unsigned SYNC_STEP = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [11:0]              line_len_i,
  input  logic [7:0]               sync_width_i,
  input  logic [7:0]               sync_amp_i,
  input  logic                     setup_en_i,
  input  logic                     slave_en_i,
  input  logic                     ext_hsync_ni,
  input  logic                     blank_i,
  input  logic [NUM_CH*DATA_W-1:0] pix_i,
  output logic [NUM_CH*DATA_W-1:0] pix_o,
  output logic                     sync_o,
  output logic [11:0]              hcount_o
);
  hcfg_t cfg_in, cfg_q;
  logic  restart;
  cnt_t  cnt;

  assign cfg_in = '{len: line_len_i, width: sync_width_i, amp: sync_amp_i,
                    setup: setup_en_i, slave: slave_en_i};

  hsi_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (restart),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  hsi_line_timer u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .len_i        (cfg_q.len),
    .width_i      (cfg_q.width),
    .slave_i      (cfg_q.slave),
    .ext_hsync_ni (ext_hsync_ni),
    .restart_o    (restart),
    .sync_o       (sync_o),
    .cnt_o        (cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    hsi_lane #(
      .DATA_W    (DATA_W),
      .BLANK_LVL (BLANK_LVL),
      .PED_LVL   (PED_LVL),
      .SYNC_STEP (SYNC_STEP)
    ) u_lane (
      .sync_i  (sync_o),
      .blank_i (blank_i),
      .setup_i (cfg_q.setup),
      .amp_i   (cfg_q.amp),
      .pix_i   (pix_i[c*DATA_W +: DATA_W]),
      .pix_o   (pix_o[c*DATA_W +: DATA_W])
    );
  end

  assign hcount_o = cnt;
endmodule

// File: rtl/hsi_checker.sv
module hsi_checker #(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned BLANK_LVL = 240,
  parameter int unsigned SYNC_STEP = 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [11:0]              hcount_o,
  input logic                     sync_o,
  input logic [NUM_CH*DATA_W-1:0] pix_o,
  input logic [11:0]              len_q,
  input logic [7:0]               width_q,
  input logic [7:0]               amp_q,
  input logic                     setup_q,
  input logic                     slave_q
);
  int unsigned exp_sync_lvl;
  always_comb begin
    exp_sync_lvl = (int'(amp_q) * SYNC_STEP >= BLANK_LVL) ? 0
                 : BLANK_LVL - int'(amp_q) * SYNC_STEP;
  end

  // R1: first edge out of reset starts a line
  a_r1_first_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o == 12'd0 |=> hcount_o == 12'd1);

  // R2, R10: counter only steps, holds, or restarts at 1
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o != 12'd0 |=> (hcount_o == 12'd1) ||
                          (hcount_o == $past(hcount_o) + 12'd1) ||
                          (hcount_o == $past(hcount_o)));

  a_r2_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_q |-> hcount_o <= len_q);

  a_r3_sync_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcount_o == 12'd1 && width_q != 8'd0) |-> sync_o);

  a_r4_sync_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> int'(pix_o[DATA_W-1:0]) == exp_sync_lvl);

  a_r8_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o != 12'd0 |-> len_q >= (12'(width_q) + 12'd2));

  a_r9_hold_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o != 12'd1 |-> ($stable(len_q) && $stable(amp_q) &&
                          $stable(setup_q) && $stable(width_q)));
endmodule

bind hsync_inserter hsi_checker #(
  .DATA_W    (DATA_W),
  .NUM_CH    (NUM_CH),
  .BLANK_LVL (BLANK_LVL),
  .SYNC_STEP (SYNC_STEP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hcount_o (hcount_o),
  .sync_o   (sync_o),
  .pix_o    (pix_o),
  .len_q    (cfg_q.len),
  .width_q  (cfg_q.width),
  .amp_q    (cfg_q.amp),
  .setup_q  (cfg_q.setup),
  .slave_q  (cfg_q.slave)
);

// File: tb/hsync_inserter_test.sv
`timescale 1ns/1ps
module hsync_inserter_test;
  localparam int DW = 10;
  localparam int NC = 3;
  localparam int BLANK = 240;
  localparam int PED = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] line_len_i = 12'd20;
  logic [7:0]  sync_width_i = 8'd4;
  logic [7:0]  sync_amp_i = 8'd50;
  logic        setup_en_i = 1'b0;
  logic        slave_en_i = 1'b0;
  logic        ext_hsync_ni = 1'b1;
  logic        blank_i = 1'b1;
  logic [NC*DW-1:0] pix_i = '0;
  logic [NC*DW-1:0] pix_o;
  logic        sync_o;
  logic [11:0] hcount_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsync_inserter uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_len_i(line_len_i),
    .sync_width_i(sync_width_i), .sync_amp_i(sync_amp_i),
    .setup_en_i(setup_en_i), .slave_en_i(slave_en_i),
    .ext_hsync_ni(ext_hsync_ni), .blank_i(blank_i), .pix_i(pix_i),
    .pix_o(pix_o), .sync_o(sync_o), .hcount_o(hcount_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ch(int i);
    return int'(pix_o[i*DW +: DW]);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_line_start();
    int n = 0;
    do begin tick(); n++; end while (hcount_o != 12'd1 && n < 9000);
  endtask

  task automatic set_pix(int a, int b, int c);
    pix_i = {DW'(c), DW'(b), DW'(a)};
  endtask

  task automatic t_reset();
    #10;
    check("R1 count in reset", int'(hcount_o), 0);
    check("R1 sync in reset", int'(sync_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    tick();
    check("R1 first count", int'(hcount_o), 1);
    check("R1 first sync", int'(sync_o), 1);
  endtask

  task automatic t_master_line();
    for (int k = 1; k <= 20; k++) begin
      check("R2 count", int'(hcount_o), k);
      check("R3 sync flag", int'(sync_o), (k <= 4) ? 1 : 0);
      if (k == 1) for (int i = 0; i < NC; i++) check("R4 sync level", ch(i), BLANK - 50);
      tick();
    end
    check("R2 wrap to 1", int'(hcount_o), 1);
  endtask

  task automatic t_video();
    for (int k = 0; k < 5; k++) tick();
    blank_i = 1'b0;
    set_pix(100, 5, 1000);
    #1;
    check("R5 ch0 no setup", ch(0), 340);
    check("R7 ch1 no setup", ch(1), 245);
    check("R5 ch2 clamp", ch(2), 1023);
    setup_en_i = 1'b1;
    sync_amp_i = 8'd250;
    #1;
    check("R9 setup deferred", ch(0), 340);
    wait_line_start();
    check("R4 saturate at 0 ch0", ch(0), 0);
    check("R4 saturate at 0 ch2", ch(2), 0);
    for (int k = 0; k < 5; k++) tick();
    check("R5 ch0 pedestal", ch(0), 360);
    check("R7 ch1 pedestal", ch(1), 265);
    check("R5 ch2 clamp pedestal", ch(2), 1023);
    blank_i = 1'b1;
    #1;
    for (int i = 0; i < NC; i++) check("R6 blank level", ch(i), BLANK);
    check("R6 no sync", int'(sync_o), 0);
  endtask

  task automatic t_clamp();
    line_len_i = 12'd3;
    sync_width_i = 8'd4;
    sync_amp_i = 8'd40;
    wait_line_start();
    check("R4 new amp", ch(1), 200);
    for (int k = 1; k <= 6; k++) begin
      check("R8 clamped count", int'(hcount_o), k);
      tick();
    end
    check("R8 clamped wrap", int'(hcount_o), 1);
  endtask

  task automatic t_slave();
    int n = 0;
    line_len_i = 12'd10;
    sync_width_i = 8'd2;
    slave_en_i = 1'b1;
    wait_line_start();
    for (int k = 0; k < 14; k++) tick();
    check("R10 no internal wrap", int'(hcount_o), 15);
    ext_hsync_ni = 1'b0;
    tick();
    check("R10 ext restart", int'(hcount_o), 1);
    check("R3 slave sync", int'(sync_o), 1);
    tick(); tick();
    check("R10 level low no restart", int'(hcount_o), 3);
    check("R3 sync ended", int'(sync_o), 0);
    ext_hsync_ni = 1'b1;
    while (hcount_o != 12'd4095 && n < 5000) begin tick(); n++; end
    tick();
    check("R10 hold at max", int'(hcount_o), 4095);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_master_line();
    t_video();
    t_clamp();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule